// File: doc/BRIEF.md
# Shared RAM mode controller

This block decides what a shared on-chip RAM is used for. After reset the RAM either serves no function or holds emulated EEPROM contents loaded from a flash bank. Software later moves it between three uses by writing a 2-bit command field: plain SRAM, EEPROM-emulation SRAM, or a fast-program buffer that is first filled with all ones.

Each switch runs its own setup sequence. The basic SRAM switch finishes in one cycle. The fast-program switch walks every RAM word and writes all ones to it. The EEPROM switch runs a request/acknowledge exchange with flash bank 1 and marks that bank busy while the exchange is open.

When a switch finishes, the block raises one ready flag and clears the command field. A command for the mode that is already active is refused and sets a sticky error flag. While the RAM is a program buffer, EEPROM accesses are refused with an error.

Top module: `shram_mode_ctrl`

## Requirements
- R1: After reset with `load_opt_i` low, the command field reads 0, all three ready flags and `cfg_err_o` are low, and no bank-1 request is made.
- R2: After reset with `load_opt_i` high, the block starts the EEPROM load by itself on the first clock. The command field reads 2'b11 until `bank1_ack_i`, and `eep_rdy_o` rises on the edge that samples the acknowledge.
- R3: Command 2'b10 selects basic SRAM. `basic_rdy_o` rises and the command field returns to 0 one cycle after the command is accepted.
- R4: Command 2'b01 selects fast-program mode. Starting in the cycle after acceptance, the block writes all-ones data to addresses 0 to DEPTH-1, one word per cycle and in rising order. `prog_rdy_o` rises exactly DEPTH cycles after acceptance.
- R5: Command 2'b11 selects EEPROM SRAM. `bank1_req_o` and `bank1_busy_o` stay high from the cycle after acceptance until the acknowledge is sampled. Then both drop, `eep_rdy_o` rises and the command field clears.
- R6: While a switch is in progress, the command field reads the accepted code and does not change.
- R7: At most one ready flag is high at any time, and all of them are low in the cycle after a legal command is accepted.
- R8: A command equal to the currently ready mode is ignored: the ready flags and command field do not change, and `cfg_err_o` goes high and stays high until reset.
- R9: Command writes made while a switch is in progress are ignored and raise no error.
- R10: An EEPROM access (`eep_req_i`) is granted only in the ready EEPROM mode. It is refused with `eep_err_o` while fast-program mode is ready or being entered. In all other states it gets neither a grant nor an error.
- R11: Writing 2'b00 to the command field has no effect and raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_opt_i | input | 1 | Option bit: load EEPROM image after reset |
| cmd_wr_i | input | 1 | Write strobe for the command field |
| cmd_wdata_i | input | 2 | Command code written |
| cmd_o | output | 2 | Current command field |
| basic_rdy_o | output | 1 | Basic SRAM mode ready |
| eep_rdy_o | output | 1 | EEPROM SRAM mode ready |
| prog_rdy_o | output | 1 | Fast-program buffer ready |
| cfg_err_o | output | 1 | Sticky illegal-command flag |
| bank1_req_o | output | 1 | EEPROM load request to flash bank 1 |
| bank1_busy_o | output | 1 | Bank 1 reserved by the load |
| bank1_ack_i | input | 1 | Load complete from flash bank 1 |
| ram_we_o | output | 1 | Fill write enable |
| ram_addr_o | output | AW | Fill word address |
| ram_wdata_o | output | DW | Fill data (all ones) |
| eep_req_i | input | 1 | EEPROM access request |
| eep_gnt_o | output | 1 | EEPROM access granted |
| eep_err_o | output | 1 | EEPROM access refused in program mode |

## Verification
The bench builds the block with DEPTH 4 and DW 8. With these values every fill address, the last-word boundary and the exact cycle of `prog_rdy_o` are checked on every cycle of every fill. Because each switch is short, the bench can sweep every ordered pair of source mode and command code, including repeats, idle writes and writes made during a fill. Between sweeps it varies the acknowledge delay from 0 to 2 cycles, and it probes EEPROM access gating in each settled state.

// File: rtl/shram_pkg.sv
package shram_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE  = 2'b00,
    CMD_PROG  = 2'b01,
    CMD_BASIC = 2'b10,
    CMD_EEP   = 2'b11
  } shram_cmd_e;
endpackage

// File: rtl/shram_fill_seq.sv
module shram_fill_seq #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          done_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          active_q;
  logic [AW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q) begin
      if (cnt_q == LAST) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign done_o  = active_q && (cnt_q == LAST);
  assign we_o    = active_q;
  assign addr_o  = cnt_q;
  assign wdata_o = '1;

  AST_FILL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && !done_o |=> active_q && cnt_q == $past(cnt_q) + 1'b1); // R4
  AST_FILL_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q); // R4
endmodule

// File: rtl/shram_eep_loader.sv
module shram_eep_loader (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             req_q <= 1'b0;
    else if (start_i)        req_q <= 1'b1;
    else if (req_q && ack_i) req_q <= 1'b0;
  end

  assign req_o  = req_q;
  assign done_o = req_q && ack_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q); // R5
  AST_REQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && ack_i && !start_i |=> !req_q); // R5
endmodule

// File: rtl/shram_eep_gate.sv
module shram_eep_gate (
  input  logic req_i,
  input  logic eep_mode_i,
  input  logic prog_mode_i,
  output logic gnt_o,
  output logic err_o
);
  always_comb begin
    gnt_o = req_i && eep_mode_i && !prog_mode_i;
    err_o = req_i && prog_mode_i;
  end
endmodule

// File: rtl/shram_mode_ctrl.sv
module shram_mode_ctrl
  import shram_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_opt_i,
  input  logic          cmd_wr_i,
  input  logic [1:0]    cmd_wdata_i,
  output logic [1:0]    cmd_o,
  output logic          basic_rdy_o,
  output logic          eep_rdy_o,
  output logic          prog_rdy_o,
  output logic          cfg_err_o,
  output logic          bank1_req_o,
  output logic          bank1_busy_o,
  input  logic          bank1_ack_i,
  output logic          ram_we_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_wdata_o,
  input  logic          eep_req_i,
  output logic          eep_gnt_o,
  output logic          eep_err_o
);
  logic       boot_q;
  shram_cmd_e cmd_q;
  logic       basic_rdy_q, eep_rdy_q, prog_rdy_q, cfg_err_q;

  shram_cmd_e sw_code, start_code;
  logic busy, boot_go, same_mode, sw_try, sw_ok, sw_bad, start;
  logic fill_start, load_start, basic_done, fill_done, load_done, done_any;

  always_comb begin
    busy       = (cmd_q != CMD_IDLE);
    boot_go    = boot_q && load_opt_i;
    sw_code    = shram_cmd_e'(cmd_wdata_i);
    same_mode  = (sw_code == CMD_BASIC && basic_rdy_q) ||
                 (sw_code == CMD_EEP   && eep_rdy_q)   ||
                 (sw_code == CMD_PROG  && prog_rdy_q);
    // boot cycle owns the field; busy field ignores writes
    sw_try     = cmd_wr_i && !boot_q && !busy && (sw_code != CMD_IDLE);
    sw_ok      = sw_try && !same_mode;
    sw_bad     = sw_try && same_mode;
    start      = boot_go || sw_ok;
    start_code = boot_go ? CMD_EEP : sw_code;
    fill_start = start && (start_code == CMD_PROG);
    load_start = start && (start_code == CMD_EEP);
    basic_done = (cmd_q == CMD_BASIC);
    done_any   = basic_done || fill_done || load_done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q      <= 1'b1;
      cmd_q       <= CMD_IDLE;
      basic_rdy_q <= 1'b0;
      eep_rdy_q   <= 1'b0;
      prog_rdy_q  <= 1'b0;
      cfg_err_q   <= 1'b0;
    end else begin
      boot_q <= 1'b0;
      if (start) begin
        cmd_q       <= start_code;
        basic_rdy_q <= 1'b0;
        eep_rdy_q   <= 1'b0;
        prog_rdy_q  <= 1'b0;
      end else if (done_any) begin
        cmd_q       <= CMD_IDLE;
        basic_rdy_q <= basic_done;
        eep_rdy_q   <= load_done;
        prog_rdy_q  <= fill_done;
      end
      if (sw_bad) cfg_err_q <= 1'b1;
    end
  end

  shram_fill_seq #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_fill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (fill_start),
    .done_o  (fill_done),
    .we_o    (ram_we_o),
    .addr_o  (ram_addr_o),
    .wdata_o (ram_wdata_o)
  );

  shram_eep_loader u_load (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (load_start),
    .ack_i   (bank1_ack_i),
    .req_o   (bank1_req_o),
    .done_o  (load_done)
  );

  shram_eep_gate u_gate (
    .req_i       (eep_req_i),
    .eep_mode_i  (eep_rdy_q),
    .prog_mode_i (prog_rdy_q || cmd_q == CMD_PROG),
    .gnt_o       (eep_gnt_o),
    .err_o       (eep_err_o)
  );

  assign cmd_o        = cmd_q;
  assign basic_rdy_o  = basic_rdy_q;
  assign eep_rdy_o    = eep_rdy_q;
  assign prog_rdy_o   = prog_rdy_q;
  assign cfg_err_o    = cfg_err_q;
  assign bank1_busy_o = (cmd_q == CMD_EEP);

  AST_RDY_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({basic_rdy_q, eep_rdy_q, prog_rdy_q})); // R7
  AST_ACCEPT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !basic_rdy_q && !eep_rdy_q && !prog_rdy_q); // R7
  AST_CMD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !done_any |=> cmd_q == $past(cmd_q)); // R6
  AST_BUSY_WR_IGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_i && busy && !cfg_err_q |=> !cfg_err_q); // R9
  AST_ILLEGAL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_bad |=> cmd_q == CMD_IDLE && $stable({basic_rdy_q, eep_rdy_q, prog_rdy_q})); // R8
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_q |=> cfg_err_q); // R8
  AST_PROG_NO_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_rdy_q |-> !eep_gnt_o); // R10
  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bank1_req_o |-> bank1_busy_o); // R5
endmodule

// File: tb/shram_mode_ctrl_tb.sv
module shram_mode_ctrl_tb;
  localparam int DEPTH = 4;
  localparam int DW    = 8;
  localparam int AW    = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, load_opt, cmd_wr, bank1_ack, eep_req;
  logic [1:0]    cmd_wd, cmd_rd;
  logic          basic_rdy, eep_rdy, prog_rdy, cfg_err;
  logic          bank1_req, bank1_busy, ram_we, eep_gnt, eep_err;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;

  shram_mode_ctrl #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_opt_i(load_opt),
    .cmd_wr_i(cmd_wr), .cmd_wdata_i(cmd_wd), .cmd_o(cmd_rd),
    .basic_rdy_o(basic_rdy), .eep_rdy_o(eep_rdy), .prog_rdy_o(prog_rdy),
    .cfg_err_o(cfg_err), .bank1_req_o(bank1_req), .bank1_busy_o(bank1_busy),
    .bank1_ack_i(bank1_ack), .ram_we_o(ram_we), .ram_addr_o(ram_addr),
    .ram_wdata_o(ram_wdata), .eep_req_i(eep_req), .eep_gnt_o(eep_gnt),
    .eep_err_o(eep_err)
  );

  int total = 0, bad = 0;
  int ack_dly = 0, ack_cnt = 0;
  int cur = 0;   // code of the ready mode, 0 = none
  bit err_exp = 1'b0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  function automatic int flags_exp();
    case (cur)
      2:       return 1;
      3:       return 2;
      1:       return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int flags_act();
    return int'({prog_rdy, eep_rdy, basic_rdy});
  endfunction

  always @(negedge clk) begin
    if (bank1_req) begin
      bank1_ack = (ack_cnt == ack_dly);
      ack_cnt++;
    end else begin
      bank1_ack = 1'b0;
      ack_cnt = 0;
    end
  end

  task automatic acc_chk();
    @(negedge clk);
    eep_req = 1'b1;
    #1;
    chk(eep_gnt == (cur == 3), "R10 gnt", int'(eep_gnt), int'(cur == 3));
    chk(eep_err == (cur == 1), "R10 err", int'(eep_err), int'(cur == 1));
    eep_req = 1'b0;
  endtask

  task automatic do_cmd(input int code);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wd = 2'(code);
    @(negedge clk);
    cmd_wr = 1'b0;
    if (code == 0 || code == cur) begin
      if (code != 0) err_exp = 1'b1;
      chk(cmd_rd == 0, code == 0 ? "R11 cmd" : "R8 cmd", int'(cmd_rd), 0);
      chk(flags_act() == flags_exp(), code == 0 ? "R11 flags" : "R8 flags",
          flags_act(), flags_exp());
      chk(cfg_err == err_exp, code == 0 ? "R11 err" : "R8 err", int'(cfg_err), int'(err_exp));
    end else begin
      chk(cmd_rd == 2'(code), "R6 cmd", int'(cmd_rd), code);
      chk(flags_act() == 0, "R7 drop", flags_act(), 0);
      case (code)
        2: @(negedge clk);
        1: begin
          for (int n = 0; n < DEPTH; n++) begin
            chk(ram_we && ram_addr == AW'(n) && ram_wdata == '1, "R4 fill",
                int'(ram_addr), n);
            chk(!prog_rdy, "R4 early", int'(prog_rdy), 0);
            if (n == 1) begin
              cmd_wr = 1'b1;
              cmd_wd = 2'b10;
            end else cmd_wr = 1'b0;
            if (n == 2) begin
              chk(cmd_rd == 2'b01, "R9 cmd", int'(cmd_rd), 1);
              eep_req = 1'b1;
              #1;
              chk(eep_err && !eep_gnt, "R10 fill", int'(eep_gnt), 0);
              eep_req = 1'b0;
            end
            @(negedge clk);
          end
          cmd_wr = 1'b0;
          chk(!ram_we, "R4 stop", int'(ram_we), 0);
          chk(cfg_err == err_exp, "R9 err", int'(cfg_err), int'(err_exp));
        end
        default: begin
          for (int n = 0; n <= ack_dly; n++) begin
            chk(bank1_req && bank1_busy && !eep_rdy, "R5 hold", int'(bank1_req), 1);
            @(negedge clk);
          end
          chk(!bank1_req && !bank1_busy, "R5 release", int'(bank1_busy), 0);
        end
      endcase
      cur = code;
      chk(cmd_rd == 0, "R6 clear", int'(cmd_rd), 0);
      chk(flags_act() == flags_exp(), code == 2 ? "R3 rdy" : code == 1 ? "R4 rdy" : "R5 rdy",
          flags_act(), flags_exp());
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_opt = 1'b0; cmd_wr = 1'b0; cmd_wd = '0;
    eep_req = 1'b0; bank1_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmd_rd == 0 && flags_act() == 0 && !bank1_req && !cfg_err, "R1 idle",
          flags_act(), 0);
    end
    acc_chk();

    for (int a = 1; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        if (a != cur) do_cmd(a);
        acc_chk();
        do_cmd(b);
        acc_chk();
        ack_dly = (ack_dly + 1) % 3;
      end
    end

    // R2: automatic load after reset
    @(negedge clk);
    rst_n = 1'b0; load_opt = 1'b1; ack_dly = 2;
    cur = 0; err_exp = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int n = 0; n <= 2; n++) begin
      chk(cmd_rd == 2'b11 && bank1_req && !eep_rdy, "R2 load", int'(cmd_rd), 3);
      @(negedge clk);
    end
    chk(eep_rdy && cmd_rd == 0 && !bank1_req && !cfg_err, "R2 rdy", int'(eep_rdy), 1);
    cur = 3;
    acc_chk();
    do_cmd(3);
    do_cmd(2);
    chk(cfg_err, "R8 sticky", int'(cfg_err), 1);

    summary();
    $finish;
  end
endmodule